// File: doc/BRIEF.md
# Dual-Clock Resync FIFO with Read Start Threshold

This block carries pixel containers from a pixel-clock domain into a symbol-clock domain ahead of a display link front end. Each container holds either one pixel or two, chosen per write by a mode input, and the mode travels with the data so the consumer knows how many pixels are valid. Storage is a small ring buffer addressed by Gray-coded pointers. Each pointer crosses into the other domain through a chain of synchronizer flops.

The read side does not start draining as soon as data appears. It waits until its synchronized view of the fill level reaches a programmable start level. After that it pops one container on every symbol clock. A start level near half the depth gives the best margin against clock drift. A start level of zero makes reading begin on an empty buffer, and the sticky error flag records the resulting underflow.

Software controls the block from the pixel domain. It clears the block with a request/done handshake: raising the request flushes both sides and makes the done flag rise, and dropping the request makes done fall. Done is produced by the symbol domain, so it never rises while that clock is stopped. Data moves only while the enable input is high. Software raises enable after the reset handshake has completed.

Top module: `resync_fifo`

## Requirements
- R1: Containers accepted on the write side appear on `rdPix`/`rdPair` in write order, one per symbol clock in which `rdValid` is 1, with no loss and no duplication.
- R2: After a reset handshake, `rdValid` stays 0 until the read side's synchronized fill count is at least `cfgStartLevel`. A burst shorter than the start level produces no output.
- R3: While `cfgRstReq` is 1 and the symbol clock runs, `cfgRstDone` rises to 1. After the request drops, it returns to 0. While the symbol clock is stopped, `cfgRstDone` stays 0.
- R4: A completed reset handshake empties the buffer, clears `cfgError` and returns the read side to waiting for the start level.
- R5: While `cfgEnable` is 0, writes are ignored: nothing later emerges from them, and they raise no error.
- R6: A write while the buffer holds 2^ADDR_W containers is dropped and sets `cfgError`. The flag stays 1 until a reset handshake.
- R7: Once reading has started, a symbol cycle that finds the buffer empty sets `cfgError` (sticky). With `cfgStartLevel` = 0 this happens without any write.
- R8: With the pair mode input 0 at write, that container emerges with `rdPair` = 0 and the upper pixel field `rdPix[2*PIX_W-1:PIX_W]` all zero. With the mode input 1, both pixels emerge unchanged and `rdPair` = 1. The first pixel sits in `rdPix[PIX_W-1:0]`.
- R9: After the hard resets, `rdValid`, `cfgRstDone` and `cfgError` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Pixel-domain clock (write and control side) |
| wrRstN | input | 1 | Asynchronous active-low reset, pixel domain |
| cfgEnable | input | 1 | Enables data transfer on both sides |
| cfgRstReq | input | 1 | Reset request of the handshake |
| cfgStartLevel | input | ADDR_W+1 | Fill level at which reading starts |
| cfgPairMode | input | 1 | 1: container holds two pixels, 0: one pixel |
| wrValid | input | 1 | Write strobe for `wrPix` |
| wrPix | input | 2*PIX_W | Container, first pixel in the low field |
| cfgRstDone | output | 1 | Reset handshake done flag |
| cfgError | output | 1 | Sticky overflow/underflow flag |
| rdClk | input | 1 | Symbol-domain clock (read side) |
| rdRstN | input | 1 | Asynchronous active-low reset, symbol domain |
| rdValid | output | 1 | Output container valid this symbol cycle |
| rdPix | output | 2*PIX_W | Output container |
| rdPair | output | 1 | Pair mode that was in force when the container was written |

## Verification
Both clocks run at the same rate with offset phases. Random streams with random start levels and a pair mode that changes per word check ordering and pixel masking at a steady fill level, and the underflow that follows when each stream ends. A directed burst just below the start level, then topped up to exactly the level, separates "waits for threshold" from "reads as soon as data exists". With the symbol clock stopped, the bench fills the buffer past full, which shows overflow drops and the sticky error, and asserts a reset request that must not be acknowledged. A start level of zero must flag an error with no data written, and writes while disabled must leave no trace.

// File: rtl/resync_fifo_pkg.sv
package resync_fifo_pkg;
  // Strobes from control to datapath; each field is used in its own clock domain.
  typedef struct packed {
    logic wrEn;  // pixel domain: store container at wrAddr
    logic rdEn;  // symbol domain: fetch container at rdAddr
  } fifoStrb_t;
endpackage

// File: rtl/resync_fifo_sync.sv
module resync_fifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/resync_fifo_ctrl.sv
module resync_fifo_ctrl
  import resync_fifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              cfgEnable,
  input  logic              cfgRstReq,
  input  logic [ADDR_W:0]   cfgStartLevel,
  input  logic              wrValid,
  output logic              cfgRstDone,
  output logic              cfgError,
  input  logic              rdClk,
  input  logic              rdRstN,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output fifoStrb_t         strb
);
  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- pixel (write) domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGrayInWr;
  logic          wrFull, ovfFlag, wrDo;
  logic [1:0]    backSync;  // {ack, underflow} seen in pixel domain

  assign wrFull = (wrGray == {~rdGrayInWr[PW-1:PW-2], rdGrayInWr[PW-3:0]});
  assign wrDo   = wrValid & cfgEnable & ~cfgRstReq & ~wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      ovfFlag <= 1'b0;
    end else if (cfgRstReq) begin
      wrBin   <= '0;
      wrGray  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (wrDo) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= (wrBin + 1'b1) ^ ((wrBin + 1'b1) >> 1);
      end
      if (wrValid && cfgEnable && wrFull) ovfFlag <= 1'b1;
    end
  end

  resync_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uRdPtrSync (
    .clk(wrClk), .rstN(wrRstN), .din(rdGray), .dout(rdGrayInWr));

  resync_fifo_sync #(.W(2), .STAGES(SYNC_STAGES)) uBackSync (
    .clk(wrClk), .rstN(wrRstN), .din({rdAck, unfFlag}), .dout(backSync));

  assign cfgRstDone = backSync[1];
  assign cfgError   = ovfFlag | backSync[0];
  assign wrAddr     = wrBin[ADDR_W-1:0];

  // ---------------- symbol (read) domain ----------------
  logic [PW-1:0] rdBin, rdGray, wrGrayInRd, levelInRd, fillRd;
  logic [1:0]    ctlInRd;  // {reset request, enable}
  logic          reqRd, enRd, started, rdEmpty, rdAck, unfFlag, rdDo;

  resync_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uWrPtrSync (
    .clk(rdClk), .rstN(rdRstN), .din(wrGray), .dout(wrGrayInRd));

  resync_fifo_sync #(.W(2), .STAGES(SYNC_STAGES)) uCtlSync (
    .clk(rdClk), .rstN(rdRstN), .din({cfgRstReq, cfgEnable}), .dout(ctlInRd));

  resync_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uLevelSync (
    .clk(rdClk), .rstN(rdRstN), .din(cfgStartLevel), .dout(levelInRd));

  assign reqRd   = ctlInRd[1];
  assign enRd    = ctlInRd[0];
  assign fillRd  = grayToBin(wrGrayInRd) - rdBin;
  assign rdEmpty = (wrGrayInRd == rdGray);
  assign rdDo    = started & enRd & ~reqRd & ~rdEmpty;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin   <= '0;
      rdGray  <= '0;
      started <= 1'b0;
      unfFlag <= 1'b0;
      rdAck   <= 1'b0;
    end else begin
      rdAck <= reqRd;
      if (reqRd) begin
        rdBin   <= '0;
        rdGray  <= '0;
        started <= 1'b0;
        unfFlag <= 1'b0;
      end else begin
        if (!enRd)                           started <= 1'b0;
        else if (!started && fillRd >= levelInRd) started <= 1'b1;
        if (rdDo) begin
          rdBin  <= rdBin + 1'b1;
          rdGray <= (rdBin + 1'b1) ^ ((rdBin + 1'b1) >> 1);
        end
        if (started && enRd && rdEmpty) unfFlag <= 1'b1;
      end
    end
  end

  assign rdAddr    = rdBin[ADDR_W-1:0];
  assign strb.wrEn = wrDo;
  assign strb.rdEn = rdDo;
endmodule

// File: rtl/resync_fifo_dp.sv
module resync_fifo_dp
  import resync_fifo_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rdRstN,
  input  fifoStrb_t            strb,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 wrPair,
  input  logic [2*PIX_W-1:0]   wrPix,
  output logic                 rdValid,
  output logic [2*PIX_W-1:0]   rdPix,
  output logic                 rdPair
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int EW    = 2 * PIX_W + 1;

  logic [EW-1:0]      mem [DEPTH];
  logic [2*PIX_W-1:0] wrPixMasked;

  assign wrPixMasked = wrPair ? wrPix : {{PIX_W{1'b0}}, wrPix[PIX_W-1:0]};

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) mem[wrAddr] <= {wrPair, wrPixMasked};
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdValid <= 1'b0;
      rdPix   <= '0;
      rdPair  <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) {rdPair, rdPix} <= mem[rdAddr];
    end
  end
endmodule

// File: rtl/resync_fifo.sv
module resync_fifo
  import resync_fifo_pkg::*;
#(
  parameter int PIX_W       = 12,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                wrClk,
  input  logic                wrRstN,
  input  logic                cfgEnable,
  input  logic                cfgRstReq,
  input  logic [ADDR_W:0]     cfgStartLevel,
  input  logic                cfgPairMode,
  input  logic                wrValid,
  input  logic [2*PIX_W-1:0]  wrPix,
  output logic                cfgRstDone,
  output logic                cfgError,
  input  logic                rdClk,
  input  logic                rdRstN,
  output logic                rdValid,
  output logic [2*PIX_W-1:0]  rdPix,
  output logic                rdPair
);
  fifoStrb_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  resync_fifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .cfgEnable(cfgEnable), .cfgRstReq(cfgRstReq),
    .cfgStartLevel(cfgStartLevel), .wrValid(wrValid), .cfgRstDone(cfgRstDone),
    .cfgError(cfgError), .rdClk(rdClk), .rdRstN(rdRstN), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .strb(strb));

  resync_fifo_dp #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) uDp (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrPair(cfgPairMode), .wrPix(wrPix), .rdValid(rdValid),
    .rdPix(rdPix), .rdPair(rdPair));
endmodule

// File: rtl/resync_fifo_chk.sv
module resync_fifo_chk #(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 4
) (
  input logic               wrClk,
  input logic               wrRstN,
  input logic               rdClk,
  input logic               rdRstN,
  input logic               cfgEnable,
  input logic               cfgRstReq,
  input logic               cfgRstDone,
  input logic               cfgError,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic               rdEn,
  input logic               rdValid,
  input logic [2*PIX_W-1:0] rdPix,
  input logic               rdPair
);
  // R1: each pop advances the read address by exactly one
  p_rd_step_r1: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEn |=> (rdAddr == ADDR_W'($past(rdAddr) + 1'b1)));

  // R1: output valid only as the result of a pop issued by control
  p_valid_from_pop_r1: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdValid |-> $past(rdEn));

  // R5: no write address movement while disabled
  p_idle_when_off_r5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!cfgEnable && !cfgRstReq) |=> $stable(wrAddr));

  // R6: error stays set outside a reset handshake
  p_err_sticky_r6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (cfgError && !cfgRstReq && !cfgRstDone) |=> cfgError);

  // R8: single-pixel containers carry a zero upper field
  p_single_mask_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdValid && !rdPair) |-> (rdPix[2*PIX_W-1:PIX_W] == '0));
endmodule

bind resync_fifo resync_fifo_chk #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) uChk (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
  .cfgEnable(cfgEnable), .cfgRstReq(cfgRstReq), .cfgRstDone(cfgRstDone),
  .cfgError(cfgError), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdEn(strb.rdEn),
  .rdValid(rdValid), .rdPix(rdPix), .rdPair(rdPair));

// File: tb/resync_fifo_test.sv
module resync_fifo_test;
  localparam int PIX_W  = 12;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CW     = 2 * PIX_W;

  logic wrClk = 1'b0, rdRaw = 1'b0, rdClkOn = 1'b1;
  logic wrRstN = 1'b0, rdRstN = 1'b0;
  logic cfgEnable = 1'b0, cfgRstReq = 1'b0, cfgPairMode = 1'b0, wrValid = 1'b0;
  logic [ADDR_W:0] cfgStartLevel = 5'd7;
  logic [CW-1:0] wrPix = '0;
  logic cfgRstDone, cfgError, rdValid, rdPair;
  logic [CW-1:0] rdPix;
  wire  rdClk = rdRaw & rdClkOn;

  always #10 wrClk = ~wrClk;  // 50 MHz
  initial begin #7; forever #10 rdRaw = ~rdRaw; end

  resync_fifo #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .cfgEnable(cfgEnable), .cfgRstReq(cfgRstReq),
    .cfgStartLevel(cfgStartLevel), .cfgPairMode(cfgPairMode), .wrValid(wrValid),
    .wrPix(wrPix), .cfgRstDone(cfgRstDone), .cfgError(cfgError), .rdClk(rdClk),
    .rdRstN(rdRstN), .rdValid(rdValid), .rdPix(rdPix), .rdPair(rdPair));

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  logic [CW:0] expQ[$], gotQ[$];

  always @(negedge rdClk) if (rdValid) gotQ.push_back({rdPair, rdPix});

  function automatic logic [CW:0] expWord(input logic [CW-1:0] pix, input logic pair);
    return pair ? {1'b1, pix} : {1'b0, {PIX_W{1'b0}}, pix[PIX_W-1:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrCycles(input int n);
    repeat (n) @(negedge wrClk);
  endtask

  task automatic setRdClock(input logic on);
    @(negedge rdRaw);
    rdClkOn = on;
  endtask

  task automatic waitDone(input logic val, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge wrClk);
      if (cfgRstDone == val) begin seen = 1'b1; break; end
    end
  endtask

  task automatic doReset();
    bit seen;
    cfgEnable = 1'b0;
    wrCycles(8);
    cfgRstReq = 1'b1;
    waitDone(1'b1, seen);
    check(seen, "R3 done rises on request", cfgRstDone, 1);
    cfgRstReq = 1'b0;
    waitDone(1'b0, seen);
    check(seen, "R3 done falls on release", cfgRstDone, 0);
    check(cfgError == 1'b0, "R4 error cleared by reset", cfgError, 0);
    expQ.delete();
    gotQ.delete();
  endtask

  task automatic putWord(input logic [CW-1:0] pix, input logic pair, input bit keep);
    @(negedge wrClk);
    wrValid = 1'b1; wrPix = pix; cfgPairMode = pair;
    if (keep) expQ.push_back(expWord(pix, pair));
  endtask

  task automatic stopWr();
    @(negedge wrClk);
    wrValid = 1'b0;
  endtask

  task automatic compareStreams(input string tag);
    int bad = -1;
    check(gotQ.size() == expQ.size(), {tag, " count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
      if (gotQ[i] !== expQ[i]) begin bad = i; break; end
    if (bad >= 0) check(1'b0, {tag, " data"}, gotQ[bad], expQ[bad]);
    else          check(1'b1, {tag, " data"}, 0, 0);
  endtask

  initial begin
    bit seen;
    void'($urandom(32'h1d5e_0077));
    wrCycles(3);
    wrRstN = 1'b1; rdRstN = 1'b1;
    wrCycles(2);
    check(rdValid == 1'b0, "R9 reset rdValid", rdValid, 0);
    check(cfgRstDone == 1'b0, "R9 reset done", cfgRstDone, 0);
    check(cfgError == 1'b0, "R9 reset error", cfgError, 0);

    // R5: disabled writes leave nothing behind
    doReset();
    for (int i = 0; i < 10; i++) putWord(CW'(i + 1), 1'b1, 1'b0);
    stopWr();
    wrCycles(40);
    check(gotQ.size() == 0, "R5 disabled writes produce no output", gotQ.size(), 0);
    check(cfgError == 1'b0, "R5 disabled writes raise no error", cfgError, 0);

    // R2: below threshold no output; reaching it exactly starts reading
    cfgStartLevel = 5'd8;
    doReset();
    cfgEnable = 1'b1;
    wrCycles(6);
    for (int i = 0; i < 5; i++) putWord(CW'(24'h100 + i), 1'b0, 1'b1);
    stopWr();
    wrCycles(40);
    check(gotQ.size() == 0, "R2 burst below start level held", gotQ.size(), 0);
    check(cfgError == 1'b0, "R7 no underflow before start", cfgError, 0);
    for (int i = 0; i < 3; i++) putWord(CW'(24'hABC000 + i), 1'b1, 1'b1);
    stopWr();
    wrCycles(60);
    compareStreams("R1 R2 threshold burst");
    check(cfgError == 1'b1, "R7 underflow after drain", cfgError, 1);

    // R6: overflow with symbol clock stopped
    cfgStartLevel = 5'd4;
    doReset();
    cfgEnable = 1'b1;
    wrCycles(10);
    setRdClock(1'b0);
    for (int i = 0; i < DEPTH + 4; i++) putWord(CW'(24'h5A0000 + i * 3), i[0], i < DEPTH);
    stopWr();
    wrCycles(8);
    check(cfgError == 1'b1, "R6 overflow sets error", cfgError, 1);
    setRdClock(1'b1);
    wrCycles(60);
    compareStreams("R1 R6 contents after overflow");
    check(cfgError == 1'b1, "R6 error sticky", cfgError, 1);
    doReset();
    check(cfgError == 1'b0, "R6 R4 error cleared only by reset", cfgError, 0);

    // R3: no done while symbol clock is off
    setRdClock(1'b0);
    cfgRstReq = 1'b1;
    wrCycles(30);
    check(cfgRstDone == 1'b0, "R3 no done with symbol clock off", cfgRstDone, 0);
    setRdClock(1'b1);
    waitDone(1'b1, seen);
    check(seen, "R3 done after clock resumes", cfgRstDone, 1);
    cfgRstReq = 1'b0;
    waitDone(1'b0, seen);
    check(seen, "R3 done falls after release", cfgRstDone, 0);

    // R7: start level zero underflows with no data
    cfgStartLevel = 5'd0;
    doReset();
    cfgEnable = 1'b1;
    wrCycles(20);
    check(cfgError == 1'b1, "R7 zero start level flags error", cfgError, 1);
    check(gotQ.size() == 0, "R7 zero start level outputs nothing", gotQ.size(), 0);

    // R1 R8: random streams, per-word pair mode, random start level
    for (int it = 0; it < 6; it++) begin
      int n;
      cfgStartLevel = ADDR_W'(1 + $urandom % 6);
      doReset();
      cfgEnable = 1'b1;
      n = 20 + $urandom % 40;
      for (int i = 0; i < n; i++) begin
        putWord(CW'($urandom), 1'($urandom), 1'b1);
        if (i == n - 2)
          check(cfgError == 1'b0, "R7 no error during steady stream", cfgError, 0);
      end
      stopWr();
      wrCycles(60);
      compareStreams("R1 R8 random stream");
      check(cfgError == 1'b1, "R7 underflow at stream end", cfgError, 1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule